// File: doc/BRIEF.md
# Task and Event Control Block for a Serial Peripheral

This block is the control shell that wraps a serial peripheral core. Software reaches it through a small register bus (address, write enable, write data, combinational read data). Writing a one to one of four task addresses sends a single-cycle strobe to the core (start, stop, suspend, resume). Single-cycle pulses from the core for five conditions (started, receive-done, both-done, transmit-done, stopped) are captured into sticky flags that software reads and clears by writing zero. A level interrupt is raised whenever a captured flag is also unmasked.

Besides software, tasks can be fired by hardware. Each task has a subscribe register that ties it to one of 2^CH_W broadcast channels, and each event has a publish register that forwards its pulse onto a chosen channel. A shortcut bit lets every both-done pulse restart the transfer on its own. A global on/off register gates all task strobes, flag capture and publishing.

Top module: `tec_top`

## Requirements
- R1: After reset the task strobes, channel outputs and interrupt are low, and the on/off register (0x400) and the interrupt mask read 0.
- R2: Bit 0 of the on/off register at 0x400 turns the block on (1) or off (0); while off, no task strobe is produced, no event flag sets and nothing is published.
- R3: A write with data bit 0 set to task address 0x000 (start), 0x004 (stop), 0x008 (suspend) or 0x00C (resume) drives bit 0..3 of the task strobe high for exactly the one cycle after the write; a write with bit 0 clear fires nothing, and task addresses read 0.
- R4: An event pulse on input bit j sets the flag of event j (0 started, 1 receive-done, 2 both-done, 3 transmit-done, 4 stopped), read as bit 0 at address 0x100 + 4*j.
- R5: Writing data with bit 0 clear to an event address clears its flag; writing bit 0 set has no effect; a pulse arriving in the same cycle as a clear leaves the flag set.
- R6: Writing ones to 0x304 sets, and writing ones to 0x308 clears, the matching bits of the interrupt mask (bit j for event j); zero bits change nothing, and both addresses read the current mask.
- R7: The interrupt output is high exactly when some event flag is set and its mask bit is set.
- R8: With bit 0 of the shortcut register at 0x200 set, each both-done pulse produces a start strobe in the following cycle.
- R9: The subscribe register of a task sits at its address plus 0x80, with the channel in bits 4:0 and the enable in bit 31; while enabled, a pulse on that channel input gives the task strobe in the next cycle, and the register reads back as written.
- R10: The publish register of an event sits at its address plus 0x80 in the same format; while enabled, each pulse of that event appears on that channel output in the next cycle.
- R11: Reads of addresses that hold no register return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write enable for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| evt_pulse | input | 5 | Single-cycle event pulses from the core |
| task_strobe | output | 4 | Single-cycle task strobes to the core |
| irq | output | 1 | Level interrupt |
| ch_in | input | 2^CH_W | Incoming broadcast channel pulses |
| ch_out | output | 2^CH_W | Outgoing broadcast channel pulses |

## Verification
The hardest situation to reach is a core pulse landing in the very cycle that software clears the same flag, since the two arrive through unrelated ports. The stimulus drives the event input and the clearing bus write on one falling edge so both are sampled at the same rising edge, then reads the flag back. Hardware-fired strobes from the shortcut and from a subscribed channel are scored against queued expectations cycle by cycle, so a strobe that is late, doubled or missing is caught.

// File: rtl/tec_pkg.sv
package tec_pkg;
  localparam int DATA_W     = 32;
  localparam int NUM_TASK   = 4;
  localparam int NUM_EVT    = 5;
  localparam int TASK_BASE  = 'h000;
  localparam int EVT_BASE   = 'h100;
  localparam int LINK_OFS   = 'h080;
  localparam int SHORT_ADDR = 'h200;
  localparam int MASK_SET   = 'h304;
  localparam int MASK_CLR   = 'h308;
  localparam int ON_ADDR    = 'h400;
  localparam int LINK_EN    = 31;
  localparam int TASK_START = 0;
  localparam int EVT_BOTH   = 2;
endpackage

// File: rtl/tec_task_unit.sv
module tec_task_unit #(
  parameter int CH_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 sw_fire,
  input  logic                 hw_fire,
  input  logic                 cfg_we,
  input  logic                 cfg_en,
  input  logic [CH_W-1:0]      cfg_ch,
  input  logic [(1<<CH_W)-1:0] ch_in,
  output logic                 strobe,
  output logic                 link_en,
  output logic [CH_W-1:0]      link_ch
);
  logic            strobe_d;
  logic            link_en_d;
  logic [CH_W-1:0] link_ch_d;

  always_comb begin
    link_en_d = link_en;
    link_ch_d = link_ch;
    if (cfg_we) begin
      link_en_d = cfg_en;
      link_ch_d = cfg_ch;
    end
    strobe_d = enable & (sw_fire | hw_fire | (link_en & ch_in[link_ch]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe  <= 1'b0;
      link_en <= 1'b0;
      link_ch <= '0;
    end else begin
      strobe  <= strobe_d;
      link_en <= link_en_d;
      link_ch <= link_ch_d;
    end
  end

  // R2
  task_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !strobe);
  // R3
  task_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && sw_fire) |=> strobe);
endmodule

// File: rtl/tec_event_unit.sv
module tec_event_unit #(
  parameter int CH_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 pulse,
  input  logic                 clr_req,
  input  logic                 cfg_we,
  input  logic                 cfg_en,
  input  logic [CH_W-1:0]      cfg_ch,
  output logic                 flag,
  output logic                 link_en,
  output logic [CH_W-1:0]      link_ch,
  output logic [(1<<CH_W)-1:0] pub_vec
);
  logic            flag_d;
  logic            link_en_d;
  logic [CH_W-1:0] link_ch_d;
  logic            hit;

  always_comb begin
    hit       = enable & pulse;
    flag_d    = hit | (flag & ~clr_req);
    link_en_d = link_en;
    link_ch_d = link_ch;
    if (cfg_we) begin
      link_en_d = cfg_en;
      link_ch_d = cfg_ch;
    end
    pub_vec = '0;
    if (hit && link_en) pub_vec[link_ch] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      link_en <= 1'b0;
      link_ch <= '0;
    end else begin
      flag    <= flag_d;
      link_en <= link_en_d;
      link_ch <= link_ch_d;
    end
  end

  // R5
  pulse_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && pulse) |=> flag);
  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !(enable && pulse)) |=> !flag);
  // R2
  flag_hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !flag) |=> !flag);
endmodule

// File: rtl/tec_top.sv
module tec_top
  import tec_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CH_W   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_EVT-1:0]   evt_pulse,
  output logic [NUM_TASK-1:0]  task_strobe,
  output logic                 irq,
  input  logic [(1<<CH_W)-1:0] ch_in,
  output logic [(1<<CH_W)-1:0] ch_out
);
  localparam int NUM_CH = 1 << CH_W;

  logic                enable_q, enable_d;
  logic                short_q, short_d;
  logic [NUM_EVT-1:0]  mask_q, mask_d;
  logic [NUM_CH-1:0]   ch_out_d;
  logic [NUM_EVT-1:0]  flags;
  logic [NUM_TASK-1:0] t_link_en;
  logic [CH_W-1:0]     t_link_ch [NUM_TASK];
  logic [NUM_EVT-1:0]  e_link_en;
  logic [CH_W-1:0]     e_link_ch [NUM_EVT];
  logic [NUM_CH-1:0]   e_pub [NUM_EVT];
  logic                wdata_unused;

  assign wdata_unused = ^bus_wdata;

  for (genvar i = 0; i < NUM_TASK; i++) begin : g_task
    logic hw;
    if (i == TASK_START) begin : g_short
      assign hw = short_q & evt_pulse[EVT_BOTH];
    end else begin : g_none
      assign hw = 1'b0;
    end
    tec_task_unit #(.CH_W(CH_W)) u_task (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (enable_q),
      .sw_fire (bus_we && bus_addr == ADDR_W'(TASK_BASE + 4*i) && bus_wdata[0]),
      .hw_fire (hw),
      .cfg_we  (bus_we && bus_addr == ADDR_W'(TASK_BASE + LINK_OFS + 4*i)),
      .cfg_en  (bus_wdata[LINK_EN]),
      .cfg_ch  (bus_wdata[CH_W-1:0]),
      .ch_in   (ch_in),
      .strobe  (task_strobe[i]),
      .link_en (t_link_en[i]),
      .link_ch (t_link_ch[i])
    );
  end

  for (genvar j = 0; j < NUM_EVT; j++) begin : g_evt
    tec_event_unit #(.CH_W(CH_W)) u_evt (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (enable_q),
      .pulse   (evt_pulse[j]),
      .clr_req (bus_we && bus_addr == ADDR_W'(EVT_BASE + 4*j) && !bus_wdata[0]),
      .cfg_we  (bus_we && bus_addr == ADDR_W'(EVT_BASE + LINK_OFS + 4*j)),
      .cfg_en  (bus_wdata[LINK_EN]),
      .cfg_ch  (bus_wdata[CH_W-1:0]),
      .flag    (flags[j]),
      .link_en (e_link_en[j]),
      .link_ch (e_link_ch[j]),
      .pub_vec (e_pub[j])
    );
  end

  always_comb begin
    enable_d = enable_q;
    short_d  = short_q;
    mask_d   = mask_q;
    if (bus_we) begin
      if (bus_addr == ADDR_W'(ON_ADDR))    enable_d = bus_wdata[0];
      if (bus_addr == ADDR_W'(SHORT_ADDR)) short_d  = bus_wdata[0];
      if (bus_addr == ADDR_W'(MASK_SET))   mask_d   = mask_q | bus_wdata[NUM_EVT-1:0];
      if (bus_addr == ADDR_W'(MASK_CLR))   mask_d   = mask_q & ~bus_wdata[NUM_EVT-1:0];
    end
    ch_out_d = '0;
    for (int j = 0; j < NUM_EVT; j++) ch_out_d = ch_out_d | e_pub[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= 1'b0;
      short_q  <= 1'b0;
      mask_q   <= '0;
      ch_out   <= '0;
    end else begin
      enable_q <= enable_d;
      short_q  <= short_d;
      mask_q   <= mask_d;
      ch_out   <= ch_out_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(ON_ADDR))    bus_rdata[0] = enable_q;
    if (bus_addr == ADDR_W'(SHORT_ADDR)) bus_rdata[0] = short_q;
    if (bus_addr == ADDR_W'(MASK_SET) || bus_addr == ADDR_W'(MASK_CLR))
      bus_rdata[NUM_EVT-1:0] = mask_q;
    for (int i = 0; i < NUM_TASK; i++) begin
      if (bus_addr == ADDR_W'(TASK_BASE + LINK_OFS + 4*i)) begin
        bus_rdata[LINK_EN]    = t_link_en[i];
        bus_rdata[CH_W-1:0]   = t_link_ch[i];
      end
    end
    for (int j = 0; j < NUM_EVT; j++) begin
      if (bus_addr == ADDR_W'(EVT_BASE + 4*j)) bus_rdata[0] = flags[j];
      if (bus_addr == ADDR_W'(EVT_BASE + LINK_OFS + 4*j)) begin
        bus_rdata[LINK_EN]    = e_link_en[j];
        bus_rdata[CH_W-1:0]   = e_link_ch[j];
      end
    end
  end

  assign irq = |(flags & mask_q);

  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(MASK_CLR) && (&bus_wdata[NUM_EVT-1:0])) |=> !irq);
  // R8
  shortcut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (short_q && enable_q && evt_pulse[EVT_BOTH]) |=> task_strobe[TASK_START]);
  // R2
  publish_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_q |=> (ch_out == '0));
endmodule

// File: tb/tec_top_test.sv
module tec_top_test;
  localparam int ADDR_W = 12;
  localparam int CH_W   = 5;
  localparam int NUM_CH = 1 << CH_W;

  typedef struct {
    int          cyc;
    logic [3:0]  st;
    logic [31:0] ch;
    string       req;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_we = 1'b0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [4:0]        evt_pulse = '0;
  logic [3:0]        task_strobe;
  logic              irq;
  logic [NUM_CH-1:0] ch_in = '0;
  logic [NUM_CH-1:0] ch_out;

  int   total = 0;
  int   bad   = 0;
  int   cyc   = 0;
  bit   done  = 1'b0;
  exp_t q[$];

  tec_top #(.ADDR_W(ADDR_W), .CH_W(CH_W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
    .task_strobe(task_strobe), .irq(irq), .ch_in(ch_in), .ch_out(ch_out)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares registered outputs against queued expectations
  always @(negedge clk) begin
    if (rst_n) begin
      if (q.size() > 0 && q[0].cyc == cyc) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (task_strobe !== e.st || ch_out !== e.ch) begin
          bad++;
          $display("FAIL %s: strobe=%h ch=%h expected strobe=%h ch=%h",
                   e.req, task_strobe, ch_out, e.st, e.ch);
        end
      end else if (task_strobe !== 4'h0 || ch_out !== '0) begin
        total++;
        bad++;
        $display("FAIL R3 R9 R10 unexpected: strobe=%h ch=%h expected strobe=0 ch=0",
                 task_strobe, ch_out);
      end
    end
  end

  task automatic push(input logic [3:0] st, input logic [31:0] ch, input string req);
    exp_t e;
    if (st != 0 || ch != 0) begin
      e.cyc = cyc + 1; e.st = st; e.ch = ch; e.req = req;
      q.push_back(e);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d,
                    input logic [3:0] st, input logic [31:0] ch, input string req);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
    push(st, ch, req);
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic drive(input logic [4:0] ev, input logic [NUM_CH-1:0] ci,
                       input logic [3:0] st, input logic [31:0] ch, input string req);
    @(negedge clk);
    evt_pulse = ev; ch_in = ci;
    push(st, ch, req);
    @(negedge clk);
    evt_pulse = '0; ch_in = '0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_addr = ADDR_W'(a);
    #1;
    total++;
    if (bus_rdata !== exp) begin
      bad++;
      $display("FAIL %s: addr=%h read=%h expected=%h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string req);
    @(negedge clk);
    #1;
    total++;
    if (irq !== exp) begin
      bad++;
      $display("FAIL %s: irq=%b expected=%b", req, irq, exp);
    end
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd('h400, 0, "R1 on/off");
    rd('h304, 0, "R1 mask");
    chk_irq(1'b0, "R1 irq");
    // R2 disabled: nothing fires or sets
    wr('h000, 1, 4'h0, 0, "R2 task off");
    drive(5'b00100, '0, 4'h0, 0, "R2 event off");
    rd('h108, 0, "R2 flag off");
    wr('h400, 1, 4'h0, 0, "R2 turn on");
    rd('h400, 1, "R2 on readback");
    // R3 tasks
    for (int i = 0; i < 4; i++) wr(4*i, 1, 4'(1 << i), 0, "R3 task strobe");
    wr('h004, 0, 4'h0, 0, "R3 zero write");
    rd('h000, 0, "R3 task reads 0");
    // R4 flag capture
    drive(5'b00001, '0, 4'h0, 0, "R4");
    rd('h100, 1, "R4 started flag");
    rd('h104, 0, "R4 other flag");
    chk_irq(1'b0, "R7 masked");
    // R6 mask set/clear
    wr('h304, 'h01, 4'h0, 0, "R6");
    chk_irq(1'b1, "R7 unmasked");
    rd('h304, 'h01, "R6 set read");
    rd('h308, 'h01, "R6 clr read");
    wr('h304, 'h14, 4'h0, 0, "R6");
    rd('h304, 'h15, "R6 set more");
    wr('h308, 'h04, 4'h0, 0, "R6");
    rd('h304, 'h11, "R6 clear one");
    wr('h308, 'h00, 4'h0, 0, "R6");
    rd('h308, 'h11, "R6 zero no effect");
    // R5 clear semantics
    wr('h100, 1, 4'h0, 0, "R5");
    rd('h100, 1, "R5 write one keeps");
    wr('h100, 0, 4'h0, 0, "R5");
    rd('h100, 0, "R5 cleared");
    chk_irq(1'b0, "R7 after clear");
    @(negedge clk);
    bus_we = 1'b1; bus_addr = ADDR_W'('h100); bus_wdata = 0; evt_pulse = 5'b00001;
    @(negedge clk);
    bus_we = 1'b0; evt_pulse = '0;
    rd('h100, 1, "R5 pulse wins");
    wr('h100, 0, 4'h0, 0, "R5");
    // R8 shortcut
    wr('h200, 1, 4'h0, 0, "R8");
    rd('h200, 1, "R8 readback");
    drive(5'b00100, '0, 4'h1, 0, "R8 restart");
    wr('h200, 0, 4'h0, 0, "R8");
    drive(5'b00100, '0, 4'h0, 0, "R8 off");
    // R9 subscribe stop task to channel 7
    wr('h084, 32'h8000_0007, 4'h0, 0, "R9");
    rd('h084, 32'h8000_0007, "R9 readback");
    drive('0, NUM_CH'(1) << 7, 4'h2, 0, "R9 channel fire");
    drive('0, NUM_CH'(1) << 6, 4'h0, 0, "R9 other channel");
    // R10 publish transmit-done on channel 19
    wr('h18C, 32'h8000_0013, 4'h0, 0, "R10");
    rd('h18C, 32'h8000_0013, "R10 readback");
    drive(5'b01000, '0, 4'h0, 32'h0008_0000, "R10 publish");
    // R11 unused addresses
    rd('h3F0, 0, "R11");
    rd('h210, 0, "R11");
    // R2 off again
    wr('h400, 0, 4'h0, 0, "R2 turn off");
    wr('h10C, 0, 4'h0, 0, "R2");
    drive(5'b01000, NUM_CH'(1) << 7, 4'h0, 0, "R2 off gates");
    rd('h10C, 0, "R2 flag stays clear");
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      total++;
      bad++;
      $display("FAIL R3: pending=%0d expected=0", q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule